// File: doc/BRIEF.md
# Serial Word Receiver With Overflow

This block receives framed 32-bit data words from a single serial line and hands them to a host over a shared tri-state parallel bus. The serial side delivers one data bit per bit period, together with a one-clock strobe that marks the bit as valid. A stretch with no strobes that lasts longer than two bit periods is a line gap. A gap always ends a reception.

Each reception opens with a start marker bit and a word-type bit. After these come the data bits, least significant first. A parity bit follows the data when parity is on. In normal mode one word is taken per reception. In burst mode the block keeps taking words at fixed bit-count boundaries until the gap arrives, with no further framing between words.

Each finished word goes into an output latch and sets a ready flag. The host reads the latch as two 16-bit halves by raising two read strobes. The word counts as consumed only when the upper-half strobe ends. If a new word arrives before that, it overwrites the latch and sets a sticky overflow flag. A parity mismatch sets a sticky error flag, and the word is still latched. An explicit clear input resets both sticky flags.

Top module: `serial_word_rx`

## Requirements
- R1: After synchronous reset, data_rdy, ovf and par_err are all 0.
- R2: A reception starts with the first strobed bit after a gap or after reset. This bit must be 1. The next bit is a type bit of any value and is skipped. The next 32 bits form the word, and the first of them is bit 0. If the first bit is 0, the whole reception is ignored until the next gap.
- R3: While rd_lo is 1, dbus[15:0] carries latch bits 15:0. While rd_hi is 1, dbus[31:16] carries latch bits 31:16. A half whose strobe is 0 is high-impedance.
- R4: data_rdy becomes 1 two clocks after the strobe edge of a word's final bit. It returns to 0 on the clock edge that first samples rd_hi low after it was high.
- R5: When par_en is 1, a parity bit follows the 32 data bits. With par_odd=1 the total count of ones over the data and parity bits must be odd; with par_odd=0 it must be even. On a mismatch the word is still latched and par_err is set and stays set.
- R6: When par_en is 0, the word is complete after its 32nd data bit.
- R7: With burst_en=1, words follow one another at every 32 bits (33 when parity is on), with no start or type bits between them, until a gap.
- R8: With burst_en=0, bits received after the first word are ignored until the next gap.
- R9: A gap is more than 2*CLKS_PER_BIT clocks without a bit strobe. A gap in the middle of a word discards that partial word, so data_rdy does not rise.
- R10: If a word is latched while data_rdy is still 1, the new word replaces the old one and ovf becomes 1 and stays 1.
- R11: A one-clock pulse on clr_flags clears ovf and par_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_d | input | 1 | Serial data bit |
| bit_stb | input | 1 | One-clock strobe marking ser_d as a valid bit |
| burst_en | input | 1 | 1 = multi-word reception |
| par_en | input | 1 | 1 = parity bit present and checked |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| rd_lo | input | 1 | Drive lower latch half onto the bus |
| rd_hi | input | 1 | Drive upper latch half; falling edge completes the read |
| clr_flags | input | 1 | Clears the sticky overflow and parity flags |
| dbus | inout | 32 | Tri-state parallel data bus |
| data_rdy | output | 1 | Unread word present in the latch |
| ovf | output | 1 | Sticky overflow flag |
| par_err | output | 1 | Sticky parity error flag |

## Verification
Single words with parity off and with parity on in both senses are sent. These show whether the boundary moves from 32 to 33 bits, and whether odd and even checking are told apart by a deliberate bad parity bit. A burst of several words, sent once with parity and once without, shows whether word boundaries are found without framing. The same frame followed by extra bits in normal mode shows whether those bits are discarded. A frame with a zero start bit, a frame cut by a gap, a long pause that stays under the gap length, and a second word sent while the first is unread separate rejection, discard, tolerance and overflow behaviour.

// File: rtl/swr_pkg.sv
package swr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TYPE,
    ST_DATA,
    ST_PAR,
    ST_DROP
  } rx_state_e;
endpackage

// File: rtl/swr_gap_det.sv
module swr_gap_det #(
  parameter int CLKS_PER_BIT = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_stb,
  output logic gap
);
  localparam int GAP_CLKS = 2 * CLKS_PER_BIT + 1;
  localparam int CNT_W    = $clog2(GAP_CLKS + 1);

  logic [CNT_W-1:0] idle_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      idle_cnt <= CNT_W'(GAP_CLKS);
      gap      <= 1'b0;
    end else if (bit_stb) begin
      idle_cnt <= '0;
      gap      <= 1'b0;
    end else if (idle_cnt < CNT_W'(GAP_CLKS)) begin
      idle_cnt <= idle_cnt + 1'b1;
      gap      <= (idle_cnt == CNT_W'(GAP_CLKS - 1));
    end else begin
      gap      <= 1'b0;
    end
  end

  // R9: a gap is only flagged after a strobe-free cycle
  assert_gap_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    gap |-> $past(!bit_stb));
endmodule

// File: rtl/swr_deframer.sv
module swr_deframer
  import swr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_d,
  input  logic              bit_stb,
  input  logic              gap,
  input  logic              burst_en,
  input  logic              par_en,
  input  logic              par_odd,
  output logic              word_vld,
  output logic [DATA_W-1:0] word,
  output logic              word_perr
);
  localparam int CNT_W = $clog2(DATA_W);

  rx_state_e         st;
  logic [CNT_W-1:0]  bit_cnt;
  logic [DATA_W-1:0] sreg;
  logic [DATA_W-1:0] shifted;
  logic              acc;

  always_comb shifted = {ser_d, sreg[DATA_W-1:1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      bit_cnt   <= '0;
      sreg      <= '0;
      acc       <= 1'b0;
      word_vld  <= 1'b0;
      word      <= '0;
      word_perr <= 1'b0;
    end else begin
      word_vld <= 1'b0;
      if (gap) begin
        st <= ST_IDLE;
      end else if (bit_stb) begin
        case (st)
          ST_IDLE: st <= ser_d ? ST_TYPE : ST_DROP;
          ST_TYPE: begin
            st      <= ST_DATA;
            bit_cnt <= '0;
            acc     <= 1'b0;
          end
          ST_DATA: begin
            sreg <= shifted;
            acc  <= acc ^ ser_d;
            if (bit_cnt == CNT_W'(DATA_W - 1)) begin
              bit_cnt <= '0;
              if (par_en) begin
                st <= ST_PAR;
              end else begin
                word      <= shifted;
                word_perr <= 1'b0;
                word_vld  <= 1'b1;
                acc       <= 1'b0;
                st        <= burst_en ? ST_DATA : ST_DROP;
              end
            end else begin
              bit_cnt <= bit_cnt + 1'b1;
            end
          end
          ST_PAR: begin
            word      <= sreg;
            word_perr <= ((acc ^ ser_d) != par_odd);
            word_vld  <= 1'b1;
            acc       <= 1'b0;
            bit_cnt   <= '0;
            st        <= burst_en ? ST_DATA : ST_DROP;
          end
          default: st <= ST_DROP;
        endcase
      end
    end
  end

  // R2: a word is only produced by an accepted bit
  assert_word_after_bit_R2: assert property (@(posedge clk) disable iff (rst)
    word_vld |-> $past(bit_stb));
  // R9: a gap always returns the deframer to idle
  assert_gap_idle_R9: assert property (@(posedge clk) disable iff (rst)
    gap |=> (st == ST_IDLE));
  // R8: in normal mode nothing follows a finished word until a gap
  assert_single_word_R8: assert property (@(posedge clk) disable iff (rst)
    (word_vld && !burst_en) |-> (st == ST_DROP || st == ST_IDLE));
endmodule

// File: rtl/swr_out_latch.sv
module swr_out_latch #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              word_vld,
  input  logic [DATA_W-1:0] word,
  input  logic              word_perr,
  input  logic              rd_hi,
  input  logic              clr_flags,
  output logic [DATA_W-1:0] latch_q,
  output logic              data_rdy,
  output logic              ovf,
  output logic              par_err
);
  logic rd_hi_q;
  logic hi_done;

  always_comb hi_done = rd_hi_q && !rd_hi;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_hi_q  <= 1'b0;
      latch_q  <= '0;
      data_rdy <= 1'b0;
      ovf      <= 1'b0;
      par_err  <= 1'b0;
    end else begin
      rd_hi_q <= rd_hi;
      if (clr_flags) begin
        ovf     <= 1'b0;
        par_err <= 1'b0;
      end
      if (word_vld) begin
        latch_q  <= word;
        data_rdy <= 1'b1;
        if (data_rdy && !hi_done) ovf <= 1'b1;
        if (word_perr) par_err <= 1'b1;
      end else if (hi_done) begin
        data_rdy <= 1'b0;
      end
    end
  end

  // R4: ready only drops after the upper-half read has ended
  assert_rdy_release_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(data_rdy) |-> ($past(!rd_hi) && $past(rd_hi, 2)));
  // R10: overflow stays set unless cleared
  assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    (ovf && !clr_flags) |=> ovf);
  // R10: overflow only rises from a word landing on an unread latch
  assert_ovf_cause_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf) |-> ($past(word_vld) && $past(data_rdy)));
  // R5: parity error stays set unless cleared
  assert_perr_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    (par_err && !clr_flags) |=> par_err);
endmodule

// File: rtl/serial_word_rx.sv
module serial_word_rx #(
  parameter int DATA_W       = 32,
  parameter int CLKS_PER_BIT = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_d,
  input  logic              bit_stb,
  input  logic              burst_en,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              rd_lo,
  input  logic              rd_hi,
  input  logic              clr_flags,
  inout  wire  [DATA_W-1:0] dbus,
  output logic              data_rdy,
  output logic              ovf,
  output logic              par_err
);
  localparam int HALF = DATA_W / 2;

  logic              gap;
  logic              word_vld;
  logic              word_perr;
  logic [DATA_W-1:0] word;
  logic [DATA_W-1:0] latch_q;

  swr_gap_det #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_gap (
    .clk(clk), .rst(rst), .bit_stb(bit_stb), .gap(gap)
  );

  swr_deframer #(.DATA_W(DATA_W)) u_deframe (
    .clk(clk), .rst(rst), .ser_d(ser_d), .bit_stb(bit_stb), .gap(gap),
    .burst_en(burst_en), .par_en(par_en), .par_odd(par_odd),
    .word_vld(word_vld), .word(word), .word_perr(word_perr)
  );

  swr_out_latch #(.DATA_W(DATA_W)) u_latch (
    .clk(clk), .rst(rst), .word_vld(word_vld), .word(word),
    .word_perr(word_perr), .rd_hi(rd_hi), .clr_flags(clr_flags),
    .latch_q(latch_q), .data_rdy(data_rdy), .ovf(ovf), .par_err(par_err)
  );

  assign dbus[HALF-1:0]      = rd_lo ? latch_q[HALF-1:0]      : {HALF{1'bz}};
  assign dbus[DATA_W-1:HALF] = rd_hi ? latch_q[DATA_W-1:HALF] : {(DATA_W-HALF){1'bz}};
endmodule

// File: tb/serial_word_rx_bench.sv
module serial_word_rx_bench;
  localparam int CPB = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_d = 1'b0, bit_stb = 1'b0;
  logic burst_en = 1'b0, par_en = 1'b0, par_odd = 1'b0;
  logic rd_lo = 1'b0, rd_hi = 1'b0, clr_flags = 1'b0;
  wire  [31:0] dbus;
  logic data_rdy, ovf, par_err;

  int checks = 0;
  int errors = 0;
  bit mon_en = 1'b0;
  logic [31:0] exp_q[$];

  always #10 clk = ~clk;

  serial_word_rx #(.DATA_W(32), .CLKS_PER_BIT(CPB)) u_serial_word_rx (
    .clk(clk), .rst(rst), .ser_d(ser_d), .bit_stb(bit_stb),
    .burst_en(burst_en), .par_en(par_en), .par_odd(par_odd),
    .rd_lo(rd_lo), .rd_hi(rd_hi), .clr_flags(clr_flags),
    .dbus(dbus), .data_rdy(data_rdy), .ovf(ovf), .par_err(par_err)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b, input int spacing);
    @(negedge clk);
    ser_d   = b;
    bit_stb = 1'b1;
    @(negedge clk);
    bit_stb = 1'b0;
    repeat (spacing - 1) @(negedge clk);
  endtask

  task automatic send_word(input logic [31:0] w, input logic pbit);
    for (int i = 0; i < 32; i++) send_bit(w[i], CPB);
    if (par_en) send_bit(pbit, CPB);
  endtask

  function automatic logic good_par(input logic [31:0] w);
    return par_odd ? ~^w : ^w;
  endfunction

  task automatic gap_wait();
    repeat (4 * CPB) @(negedge clk);
  endtask

  // read both halves through the bus
  task automatic read_word(output logic [31:0] w);
    @(negedge clk); rd_lo = 1'b1;
    @(negedge clk); w[15:0] = dbus[15:0]; rd_lo = 1'b0; rd_hi = 1'b1;
    @(negedge clk); w[31:16] = dbus[31:16]; rd_hi = 1'b0;
    @(negedge clk);
  endtask

  // scoreboard monitor
  initial begin
    logic [31:0] got;
    forever begin
      @(negedge clk);
      if (mon_en && data_rdy) begin
        read_word(got);
        if (exp_q.size() == 0) begin
          check("R2 R8 R9 unexpected word", got, 32'hxxxxxxxx);
        end else begin
          check("R3 R7 word on bus", got, exp_q.pop_front());
        end
        check("R4 ready cleared after upper read", {31'd0, data_rdy}, 32'd0);
      end
    end
  end

  initial begin
    repeat (400000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual running expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic drain(input string req);
    repeat (20) @(negedge clk);
    check(req, exp_q.size(), 0);
  endtask

  initial begin
    logic [31:0] w, rd;
    int t;
    repeat (3) @(negedge clk);
    check("R1 data_rdy reset", {31'd0, data_rdy}, 0);
    check("R1 ovf reset", {31'd0, ovf}, 0);
    check("R1 par_err reset", {31'd0, par_err}, 0);
    rst = 1'b0;
    gap_wait();

    // R4 timing on a single word, monitor off
    w = 32'hA5C3_0F18;
    send_bit(1'b1, CPB); send_bit(1'b0, CPB);
    for (int i = 0; i < 31; i++) send_bit(w[i], CPB);
    @(negedge clk); ser_d = w[31]; bit_stb = 1'b1;
    @(negedge clk); bit_stb = 1'b0;
    check("R4 ready not yet after one clock", {31'd0, data_rdy}, 0);
    @(negedge clk);
    check("R4 ready two clocks after last bit", {31'd0, data_rdy}, 1);
    @(negedge clk); rd_hi = 1'b1;
    @(negedge clk);
    check("R3 upper half", {16'd0, dbus[31:16]}, {16'd0, w[31:16]});
    rd_hi = 1'b0; rd_lo = 1'b1;
    @(negedge clk);
    check("R3 lower half", {16'd0, dbus[15:0]}, {16'd0, w[15:0]});
    check("R4 ready cleared on upper release", {31'd0, data_rdy}, 0);
    rd_lo = 1'b0;
    gap_wait();
    mon_en = 1'b1;

    // R6 parity off, R8 extra bits ignored in normal mode
    w = 32'h1234_5678;
    exp_q.push_back(w);
    send_bit(1'b1, CPB); send_bit(1'b1, CPB);
    send_word(w, 1'b0);
    send_word(32'hFFFF_0000, 1'b0);
    gap_wait(); drain("R6 R8 single word");

    // R2 start bit zero is rejected
    send_bit(1'b0, CPB); send_bit(1'b0, CPB);
    send_word(32'hDEAD_BEEF, 1'b0);
    gap_wait(); drain("R2 rejected frame");
    check("R2 no word after zero start", {31'd0, data_rdy}, 0);

    // R9 gap mid-word discards
    send_bit(1'b1, CPB); send_bit(1'b0, CPB);
    for (int i = 0; i < 10; i++) send_bit(i[0], CPB);
    gap_wait();
    check("R9 partial word discarded", {31'd0, data_rdy}, 0);

    // R9 a pause of two bit periods is not a gap
    w = 32'h0BAD_F00D;
    exp_q.push_back(w);
    send_bit(1'b1, CPB); send_bit(1'b0, CPB);
    for (int i = 0; i < 32; i++) send_bit(w[i], (i == 15) ? 2 * CPB : CPB);
    gap_wait(); drain("R9 long pause under gap length");

    // R5 odd and even parity, good and bad
    par_en = 1'b1;
    for (int k = 0; k < 2; k++) begin
      par_odd = k[0];
      w = 32'h8000_0003 ^ (k * 32'h0101_0101);
      exp_q.push_back(w);
      send_bit(1'b1, CPB); send_bit(1'b0, CPB);
      send_word(w, good_par(w));
      gap_wait(); drain("R5 good parity word");
      check("R5 no error on good parity", {31'd0, par_err}, 0);
      exp_q.push_back(~w);
      send_bit(1'b1, CPB); send_bit(1'b0, CPB);
      send_word(~w, ~good_par(~w));
      gap_wait(); drain("R5 bad parity word still latched");
      check("R5 error on bad parity", {31'd0, par_err}, 1);
      @(negedge clk); clr_flags = 1'b1;
      @(negedge clk); clr_flags = 1'b0;
      check("R11 par_err cleared", {31'd0, par_err}, 0);
    end

    // R7 burst with parity and without
    burst_en = 1'b1;
    for (int k = 0; k < 2; k++) begin
      par_en = (k == 0);
      par_odd = 1'b1;
      send_bit(1'b1, CPB); send_bit(1'b0, CPB);
      for (int n = 0; n < 4; n++) begin
        w = 32'h1357_9BDF * (n + 1) + k;
        exp_q.push_back(w);
        send_word(w, good_par(w));
      end
      for (int i = 0; i < 9; i++) send_bit(1'b1, CPB);
      gap_wait(); drain("R7 burst words");
      check("R7 R9 trailing partial dropped", {31'd0, data_rdy}, 0);
    end
    check("R7 no parity error in burst", {31'd0, par_err}, 0);

    // R10 overflow, R11 clear
    mon_en = 1'b0;
    burst_en = 1'b0; par_en = 1'b0;
    repeat (10) @(negedge clk);
    send_bit(1'b1, CPB); send_bit(1'b0, CPB);
    send_word(32'h1111_2222, 1'b0);
    gap_wait();
    check("R10 no overflow on first word", {31'd0, ovf}, 0);
    send_bit(1'b1, CPB); send_bit(1'b0, CPB);
    send_word(32'h3333_4444, 1'b0);
    gap_wait();
    check("R10 overflow set", {31'd0, ovf}, 1);
    read_word(rd);
    check("R10 latch overwritten", rd, 32'h3333_4444);
    t = 0;
    repeat (5) @(negedge clk);
    check("R10 overflow sticky", {31'd0, ovf}, 1);
    clr_flags = 1'b1;
    @(negedge clk); clr_flags = 1'b0;
    check("R11 overflow cleared", {31'd0, ovf}, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule